// File: doc/BRIEF.md
# Triple Frame Base Address Controller

This block picks the memory base address for the frame writer and the frame reader of a video frame store. Memory is split into three equal slots. At any time one slot receives the incoming frame, one supplies the outgoing frame, and the third holds the newest finished frame until the reader is ready for it. The writer and the reader can therefore run at different frame rates without tearing, because neither side ever touches the slot the other side is using.

Each side reports the start of its frames with a one-cycle pulse in the memory clock domain. When a write frame starts, the slot just filled becomes the newest complete frame, and the writer moves to the slot that is free. When a read frame starts, the reader takes the newest complete frame if one has arrived since its last move. If none has, it shows its current slot again. Each side has a hold input that keeps its pointer where it is. A mode input selects single buffering, where both sides share one region at offset zero.

Top module: `triple_frame_base_ctrl`

## Requirements
- R1: After reset, in triple mode, the write base is 0 and the read base is one frame span.
- R2: Every base address is slot × FRAME_SPAN, with slot in {0,1,2}. The default span is 0x00800000. A new base appears on the cycle after the clock edge that samples the pulse.
- R3: In triple mode the write base and the read base are never equal.
- R4: A write frame start with write hold low moves the writer to the slot that is neither the slot it just finished nor the slot the reader is on after the same edge.
- R5: A read frame start with read hold low moves the reader to the newest complete slot. If no frame has completed since the reader last moved, the read base is unchanged.
- R6: Until the first write frame completes after reset, read frame starts leave the read base at one frame span.
- R7: While write hold is high, a write frame start leaves the write base unchanged and records no completed frame. A later read start therefore leaves the read base unchanged.
- R8: While read hold is high, a read frame start leaves the read base unchanged. A pending completed frame is kept for a later read start.
- R9: With triple mode low, both bases are 0, and frame starts and holds have no effect. On return to triple mode the previous slots reappear.
- R10: When both frame starts arrive in the same cycle, the reader takes the frame that was complete before that cycle. The frame the writer just finished becomes the newest complete frame.
- R11: When several write frames complete between two read starts, the reader takes the most recent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset |
| triple_en | input | 1 | 1 selects three slots, 0 selects a single shared region |
| wr_frame_start | input | 1 | One-cycle pulse at the start of a write frame |
| rd_frame_start | input | 1 | One-cycle pulse at the start of a read frame |
| wr_halt | input | 1 | Keeps the write pointer on its slot |
| rd_halt | input | 1 | Keeps the read pointer on its slot |
| wr_base | output | ADDR_W | Base address for the writer |
| rd_base | output | ADDR_W | Base address for the reader |

## Verification
The internal state has three parts: the write slot, the read slot, and the newest-complete slot with its fresh flag. An error in the write or read slot shows at the ports on the next cycle as a wrong base or as two equal bases. An error in the newest-complete slot or the fresh flag stays hidden until the next read frame start. It then shows as a read base that moved when it should have held, or held when it should have moved. Random pulse and hold patterns are therefore mixed with directed sequences that place read starts right after completions, right after holds, and in the same cycle as write starts. The read base is compared on every cycle.

// File: rtl/triple_frame_base_ctrl.sv
module triple_frame_base_ctrl #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] FRAME_SPAN = 'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              triple_en,
  input  logic              wr_frame_start,
  input  logic              rd_frame_start,
  input  logic              wr_halt,
  input  logic              rd_halt,
  output logic [ADDR_W-1:0] wr_base,
  output logic [ADDR_W-1:0] rd_base
);

  localparam logic [ADDR_W-1:0] SPAN2 = FRAME_SPAN << 1;

  logic [1:0] wr_slot, rd_slot, done_slot;
  logic       fresh;
  logic [1:0] rd_next, wr_next;

  wire wr_go   = triple_en & wr_frame_start & ~wr_halt;
  wire rd_take = triple_en & rd_frame_start & ~rd_halt & fresh;

  assign rd_next = rd_take ? done_slot : rd_slot;
  assign wr_next = wr_go ? 2'd3 - wr_slot - rd_next : wr_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot   <= 2'd0;
      rd_slot   <= 2'd1;
      done_slot <= 2'd0;
      fresh     <= 1'b0;
    end else begin
      wr_slot <= wr_next;
      rd_slot <= rd_next;
      if (wr_go) begin
        done_slot <= wr_slot;
        fresh     <= 1'b1;
      end else if (rd_take) begin
        fresh <= 1'b0;
      end
    end
  end

  function automatic logic [ADDR_W-1:0] slot_base(input logic [1:0] s);
    case (s)
      2'd1:    slot_base = FRAME_SPAN;
      2'd2:    slot_base = SPAN2;
      default: slot_base = '0;
    endcase
  endfunction

  assign wr_base = triple_en ? slot_base(wr_slot) : '0;
  assign rd_base = triple_en ? slot_base(rd_slot) : '0;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot != 2'd3) && (rd_slot != 2'd3)); // R2
  AST_BASES_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    triple_en |-> (wr_base != rd_base)); // R3
  AST_WR_AVOIDS_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> (wr_slot != done_slot)); // R4
  AST_RD_STALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_frame_start && !fresh) |=> $stable(rd_slot)); // R5
  AST_WR_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_halt && !(rd_frame_start && !rd_halt && fresh)) |=> ($stable(wr_slot) && $stable(fresh))); // R7
  AST_RD_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_halt |=> $stable(rd_slot)); // R8
  AST_SINGLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !triple_en |=> ($stable(wr_slot) && $stable(rd_slot))); // R9

endmodule

// File: tb/triple_frame_base_ctrl_tb.sv
`timescale 1ns/1ps
module triple_frame_base_ctrl_tb;
  localparam int ADDR_W = 32;
  localparam logic [ADDR_W-1:0] SPAN = 32'h0080_0000;

  logic clk = 0, rst_n = 0;
  logic triple_en = 1, wr_frame_start = 0, rd_frame_start = 0, wr_halt = 0, rd_halt = 0;
  logic [ADDR_W-1:0] wr_base, rd_base;
  int checks = 0, fails = 0;
  int m_wr, m_rd, m_done, m_fresh;

  always #2 clk = ~clk;

  triple_frame_base_ctrl #(.ADDR_W(ADDR_W), .FRAME_SPAN(SPAN)) u_dut (
    .clk(clk), .rst_n(rst_n), .triple_en(triple_en),
    .wr_frame_start(wr_frame_start), .rd_frame_start(rd_frame_start),
    .wr_halt(wr_halt), .rd_halt(rd_halt), .wr_base(wr_base), .rd_base(rd_base));

  function automatic logic [ADDR_W-1:0] exp_base(input int s, input logic t);
    return t ? SPAN * s : '0;
  endfunction

  task automatic check(input string tag, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " write base"}, wr_base, exp_base(m_wr, triple_en));
    check({tag, " read base"}, rd_base, exp_base(m_rd, triple_en));
    if (triple_en) begin
      checks++;
      if (wr_base == rd_base) begin
        fails++;
        $display("FAIL R3 actual=%h expected=not %h", wr_base, rd_base);
      end
    end
  endtask

  task automatic model(input logic ws, input logic rs, input logic wh, input logic rh, input logic t);
    int rdn = m_rd;
    int fr = m_fresh;
    if (!t) return;
    if (rs && !rh && m_fresh != 0) begin rdn = m_done; fr = 0; end
    if (ws && !wh) begin m_done = m_wr; m_wr = 3 - m_wr - rdn; fr = 1; end
    m_rd = rdn;
    m_fresh = fr;
  endtask

  task automatic step(input logic ws, input logic rs, input logic wh, input logic rh,
                      input logic t, input string tag);
    @(negedge clk);
    wr_frame_start = ws; rd_frame_start = rs; wr_halt = wh; rd_halt = rh; triple_en = t;
    model(ws, rs, wh, rh, t);
    @(negedge clk);
    wr_frame_start = 0; rd_frame_start = 0;
    check_all(tag);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7781));
    m_wr = 0; m_rd = 1; m_done = 0; m_fresh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    step(0, 1, 0, 0, 1, "R6 read before first frame");
    step(0, 1, 0, 0, 1, "R6 repeat");
    step(1, 0, 0, 0, 1, "R4 first write");
    step(0, 1, 0, 0, 1, "R5 read takes newest");
    step(0, 1, 0, 0, 1, "R5 stale read holds");
    step(1, 0, 1, 0, 1, "R7 write halted");
    step(0, 1, 0, 0, 1, "R7 no completion recorded");
    step(1, 0, 0, 0, 1, "R4 write");
    step(0, 1, 0, 1, 1, "R8 read halted");
    step(0, 1, 0, 0, 1, "R8 pending kept");
    step(1, 0, 0, 0, 1, "R11 write a");
    step(1, 0, 0, 0, 1, "R11 write b");
    step(1, 0, 0, 0, 1, "R11 write c");
    step(0, 1, 0, 0, 1, "R11 newest taken");
    step(1, 0, 0, 0, 1, "R10 prep");
    step(1, 1, 0, 0, 1, "R10 simultaneous");
    step(0, 1, 0, 0, 1, "R10 follow-up read");
    step(0, 0, 0, 0, 0, "R9 single mode");
    step(1, 1, 0, 0, 0, "R9 starts ignored");
    step(1, 1, 1, 1, 0, "R9 halts ignored");
    step(0, 0, 0, 0, 1, "R9 return to triple");
    check("R2 span multiple", wr_base % SPAN, '0);
    for (int i = 0; i < 3000; i++) begin
      logic ws = ($urandom % 3) == 0;
      logic rs = ($urandom % 3) == 0;
      logic wh = ($urandom % 6) == 0;
      logic rh = ($urandom % 6) == 0;
      logic t  = ($urandom % 20) != 0;
      step(ws, rs, wh, rh, t, "R2 R4 R5 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule